// File: doc/BRIEF.md
# Three-Phase Sine-Triangle PWM Generator

This block turns an amplitude word and a phase word into gate commands for a six-switch, three-phase inverter bridge. It evaluates once per update strobe. With the intended 500 kHz strobe and the default half-period of 25 strobes, it builds a 10 kHz symmetric triangular carrier. On every strobe it compares three sinusoidal references against that shared carrier. The references sit 0, 120 and 240 degrees apart and are scaled by the amplitude word.

An upstream amplitude regulator and an upstream phase tracker feed the two input words. The block captures both words only when the carrier reaches its peak, so a reference never changes partway through a carrier period. Each inverter leg gets an upper and a lower gate. The two gates of a leg are complementary, except during a programmable dead time in which both are held low after every change of the switching decision.

Top module: `tri_phase_spwm`

## Requirements
- R1: A synchronous reset drives all six gate outputs low, returns the carrier to its bottom value with a rising direction, clears the captured amplitude and phase to zero, and clears every leg's switching state.
- R2: Outputs and internal state change only on a clock edge where `tick` is high. With `tick` low, the gates hold their values.
- R3: The carrier count runs 0,1,…,HALF_TICKS and then back down to 1, so one period is 2·HALF_TICKS ticks. The carrier level is 2·count − HALF_TICKS. With zero amplitude and zero dead time, each upper gate is high for exactly HALF_TICKS ticks of every period.
- R4: The phase word is split into a quadrant (top two bits) and an index k (the remaining bits, Q = 2^(PHASE_W−2)). The table index is k in quadrants 0 and 2, and Q−k in quadrants 1 and 3. The table value for index i is ⌊2^SINE_W·16·i·(2Q−i) / (5·(2Q)² − 4·i·(2Q−i))⌋. The magnitude is ⌊table·amplitude / 2^SINE_W⌋ and is negated in quadrants 2 and 3.
- R5: Leg j (j = 0,1,2) uses the captured phase plus ⌊(j·2^PHASE_W + 1)/3⌋, taken modulo 2^PHASE_W.
- R6: The amplitude is clamped to HALF_TICKS when it is captured, so any input at or above HALF_TICKS gives the same gates as exactly HALF_TICKS.
- R7: Amplitude and phase are captured only on a tick where the carrier count equals HALF_TICKS. At any other time, changes on those inputs have no effect.
- R8: Leg j's switching decision is high when its reference is strictly greater than the carrier level. Outside dead time, the lower gate is the inverse of the upper gate, and the two are never high together.
- R9: When a leg's decision differs from the state it is currently applying, both of its gates go low for `dead_ticks` ticks, and the new state is then applied. A new difference during the gap restarts the gap. When `dead_ticks` is 0, the switch happens on the same tick.
- R10: The gates set on a tick reflect the carrier and captured values as they stood before that tick, which is one tick of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Update strobe, one clock wide |
| amp_in | input | AMP_W | Amplitude from the regulator |
| phase_in | input | PHASE_W | Phase angle from the tracker, full turn = 2^PHASE_W |
| dead_ticks | input | DEAD_W | Dead time in ticks |
| gate_hi | output | 3 | Upper gates, bit j = leg j |
| gate_lo | output | 3 | Lower gates, bit j = leg j |

## Verification
Every gate result is due at the clock edge that carries the tick. It is judged on the carrier position and captured words that were in place before that edge. A captured amplitude or phase first shows up on the tick after the peak tick, and a dead-time gap ends exactly `dead_ticks` ticks after the change. The driver computes each tick's expected gate pair before it raises `tick` and queues it. The monitor compares the pair 5 ns after the following rising edge, so every comparison falls in the cycle the result appears. The ignore and hold cases are read from the gate ports between ticks.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

   // Integer rational sine approximation over a half turn of span h.
   // Returns scale * sin(pi*x/h) for 0 <= x <= h.
   function automatic longint sine_approx(input longint x, input longint h,
                                          input longint scale);
      longint p;
      p = x * (h - x);
      return (scale * 16 * p) / (5 * h * h - 4 * p);
   endfunction

   typedef struct packed {
      logic hi;
      logic lo;
   } leg_gate_t;

endpackage

// File: rtl/pwm_carrier.sv
module pwm_carrier #(
   parameter int HALF_TICKS = 25,
   localparam int CW = $clog2(HALF_TICKS + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tick,
   output logic [CW-1:0] count,
   output logic          at_peak
);

   logic rising;

   always_ff @(posedge clk) begin
      if (rst) begin
         count  <= '0;
         rising <= 1'b1;
      end else if (tick) begin
         if (rising) begin
            if (count == CW'(HALF_TICKS - 1)) rising <= 1'b0;
            count <= count + 1'b1;
         end else begin
            if (count == CW'(1)) rising <= 1'b1;
            count <= count - 1'b1;
         end
      end
   end

   assign at_peak = (count == CW'(HALF_TICKS));

endmodule

// File: rtl/pwm_sine_ref.sv
module pwm_sine_ref #(
   parameter int PHASE_W = 8,
   parameter int SINE_W  = 12,
   parameter int CW      = 5,
   localparam int KW = PHASE_W - 2,
   localparam int Q  = 2 ** KW,
   localparam int RW = CW + 2
) (
   input  logic [PHASE_W-1:0]   phase,
   input  logic [CW-1:0]        amp,
   output logic signed [RW-1:0] ref_level
);
   import pwm_pkg::*;

   logic [SINE_W:0] table_q [Q+1];

   for (genvar gi = 0; gi <= Q; gi++) begin : g_tab
      assign table_q[gi] = (SINE_W+1)'(sine_approx(gi, 2 * Q, 2 ** SINE_W));
   end

   logic [1:0]       quad;
   logic [KW-1:0]    idx_raw;
   logic [KW:0]      idx;
   logic [SINE_W:0]  mag_unit;
   logic [SINE_W+CW:0] prod;
   logic [CW-1:0]    scaled;

   assign quad     = phase[PHASE_W-1 -: 2];
   assign idx_raw  = phase[KW-1:0];
   assign idx      = quad[0] ? ((KW+1)'(Q) - {1'b0, idx_raw}) : {1'b0, idx_raw};
   assign mag_unit = table_q[idx];
   assign prod     = (SINE_W+CW+1)'(mag_unit) * (SINE_W+CW+1)'(amp);
   assign scaled   = CW'(prod >> SINE_W);
   assign ref_level = quad[1] ? -$signed({2'b00, scaled}) : $signed({2'b00, scaled});

endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband #(
   parameter int DEAD_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              demand,
   input  logic [DEAD_W-1:0] dead,
   output pwm_pkg::leg_gate_t gate
);

   logic              applied;
   logic [DEAD_W-1:0] remain;

   always_ff @(posedge clk) begin
      if (rst) begin
         applied <= 1'b0;
         remain  <= '0;
         gate    <= '0;
      end else if (tick) begin
         if (demand != applied) begin
            applied <= demand;
            remain  <= dead;
            gate.hi <= (dead == '0) & demand;
            gate.lo <= (dead == '0) & ~demand;
         end else if (remain != '0) begin
            remain  <= remain - 1'b1;
            gate.hi <= (remain == DEAD_W'(1)) & applied;
            gate.lo <= (remain == DEAD_W'(1)) & ~applied;
         end else begin
            gate.hi <= applied;
            gate.lo <= ~applied;
         end
      end
   end

endmodule

// File: rtl/tri_phase_spwm.sv
module tri_phase_spwm #(
   parameter int HALF_TICKS = 25,
   parameter int PHASE_W    = 8,
   parameter int AMP_W      = 8,
   parameter int SINE_W     = 12,
   parameter int DEAD_W     = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               tick,
   input  logic [AMP_W-1:0]   amp_in,
   input  logic [PHASE_W-1:0] phase_in,
   input  logic [DEAD_W-1:0]  dead_ticks,
   output logic [2:0]         gate_hi,
   output logic [2:0]         gate_lo
);
   import pwm_pkg::*;

   localparam int CW   = $clog2(HALF_TICKS + 1);
   localparam int RW   = CW + 2;
   localparam int LEGS = 3;

   if (HALF_TICKS < 2) begin : g_bad_half
      $error("HALF_TICKS must be at least 2");
   end
   if (PHASE_W < 4) begin : g_bad_phase
      $error("PHASE_W must be at least 4");
   end
   if (AMP_W < CW) begin : g_bad_amp
      $error("AMP_W must cover HALF_TICKS");
   end
   if (SINE_W < 4 || SINE_W > 24) begin : g_bad_sine
      $error("SINE_W out of range");
   end

   logic [CW-1:0]      count;
   logic               at_peak;
   logic [CW-1:0]      amp_lat;
   logic [PHASE_W-1:0] phase_lat;
   logic [CW-1:0]      amp_sat;
   logic signed [RW-1:0] carrier_lvl;

   pwm_carrier #(.HALF_TICKS(HALF_TICKS)) u_carrier (
      .clk(clk), .rst(rst), .tick(tick), .count(count), .at_peak(at_peak)
   );

   assign amp_sat = (amp_in >= AMP_W'(HALF_TICKS)) ? CW'(HALF_TICKS) : CW'(amp_in);

   always_ff @(posedge clk) begin
      if (rst) begin
         amp_lat   <= '0;
         phase_lat <= '0;
      end else if (tick && at_peak) begin
         amp_lat   <= amp_sat;
         phase_lat <= phase_in;
      end
   end

   assign carrier_lvl = $signed({1'b0, count, 1'b0}) - $signed(RW'(HALF_TICKS));

   for (genvar gl = 0; gl < LEGS; gl++) begin : g_leg
      localparam logic [PHASE_W-1:0] OFS = PHASE_W'((gl * (2 ** PHASE_W) + 1) / 3);
      logic [PHASE_W-1:0]   leg_phase;
      logic signed [RW-1:0] leg_ref;
      logic                 leg_demand;
      leg_gate_t            leg_gate;

      assign leg_phase = phase_lat + OFS;

      pwm_sine_ref #(.PHASE_W(PHASE_W), .SINE_W(SINE_W), .CW(CW)) u_ref (
         .phase(leg_phase), .amp(amp_lat), .ref_level(leg_ref)
      );

      assign leg_demand = (leg_ref > carrier_lvl);

      pwm_deadband #(.DEAD_W(DEAD_W)) u_dead (
         .clk(clk), .rst(rst), .tick(tick), .demand(leg_demand),
         .dead(dead_ticks), .gate(leg_gate)
      );

      assign gate_hi[gl] = leg_gate.hi;
      assign gate_lo[gl] = leg_gate.lo;
   end

endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
   parameter int HALF_TICKS = 25,
   parameter int PHASE_W    = 8,
   parameter int DEAD_W     = 4,
   parameter int CW         = 5
) (
   input logic               clk,
   input logic               rst,
   input logic               tick,
   input logic [DEAD_W-1:0]  dead_ticks,
   input logic [2:0]         gate_hi,
   input logic [2:0]         gate_lo,
   input logic               at_peak,
   input logic [CW-1:0]      amp_lat,
   input logic [PHASE_W-1:0] phase_lat
);

   p_reset_low_r1: assert property (@(posedge clk)
      rst |=> (gate_hi == 3'b000 && gate_lo == 3'b000));

   p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
      !tick |=> ($stable(gate_hi) && $stable(gate_lo)));

   p_amp_clamped_r6: assert property (@(posedge clk) disable iff (rst)
      amp_lat <= CW'(HALF_TICKS));

   p_capture_at_peak_r7: assert property (@(posedge clk) disable iff (rst)
      !(tick && at_peak) |=> ($stable(amp_lat) && $stable(phase_lat)));

   p_no_shoot_through_r8: assert property (@(posedge clk) disable iff (rst)
      (gate_hi & gate_lo) == 3'b000);

   for (genvar gk = 0; gk < 3; gk++) begin : g_leg_chk
      p_gap_before_hi_r9: assert property (@(posedge clk) disable iff (rst)
         ($past(dead_ticks) != '0 && $rose(gate_hi[gk])) |-> !$past(gate_lo[gk]));
      p_gap_before_lo_r9: assert property (@(posedge clk) disable iff (rst)
         ($past(dead_ticks) != '0 && $rose(gate_lo[gk])) |-> !$past(gate_hi[gk]));
   end

endmodule

bind tri_phase_spwm pwm_checker #(
   .HALF_TICKS(HALF_TICKS), .PHASE_W(PHASE_W), .DEAD_W(DEAD_W), .CW(CW)
) u_chk (
   .clk(clk), .rst(rst), .tick(tick), .dead_ticks(dead_ticks),
   .gate_hi(gate_hi), .gate_lo(gate_lo), .at_peak(at_peak),
   .amp_lat(amp_lat), .phase_lat(phase_lat)
);

// File: tb/tb_tri_phase_spwm.sv
module tb_tri_phase_spwm;

   localparam int HALF = 25;
   localparam int PW   = 8;
   localparam int AW   = 8;
   localparam int SW   = 12;
   localparam int DW   = 4;
   localparam int QN   = 2 ** (PW - 2);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          tick = 1'b0;
   logic [AW-1:0] amp_in = '0;
   logic [PW-1:0] phase_in = '0;
   logic [DW-1:0] dead_ticks = '0;
   logic [2:0]    gate_hi;
   logic [2:0]    gate_lo;

   int errors = 0;
   int checks = 0;

   tri_phase_spwm #(.HALF_TICKS(HALF), .PHASE_W(PW), .AMP_W(AW),
                    .SINE_W(SW), .DEAD_W(DW)) dut (
      .clk(clk), .rst(rst), .tick(tick), .amp_in(amp_in), .phase_in(phase_in),
      .dead_ticks(dead_ticks), .gate_hi(gate_hi), .gate_lo(gate_lo)
   );

   always #10 clk = ~clk;

   // reference model state
   int m_c, m_up, m_amp, m_ph;
   int m_cur[3], m_cnt[3], m_hi[3], m_lo[3];

   logic [5:0] exp_q[$];
   string      tag_q[$];

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic void model_reset();
      m_c = 0; m_up = 1; m_amp = 0; m_ph = 0;
      for (int k = 0; k < 3; k++) begin
         m_cur[k] = 0; m_cnt[k] = 0; m_hi[k] = 0; m_lo[k] = 0;
      end
   endfunction

   function automatic int ref_of(input int ph, input int amp);
      int q, k, i;
      longint t, p;
      q = ph / QN;
      k = ph % QN;
      i = (q % 2 == 1) ? QN - k : k;
      p = longint'(i) * (2 * QN - i);
      t = (longint'(2 ** SW) * 16 * p) / (5 * (2 * QN) * (2 * QN) - 4 * p);
      t = (t * amp) / (2 ** SW);
      return (q >= 2) ? -int'(t) : int'(t);
   endfunction

   function automatic void model_step();
      int v, s, d, ph, dt;
      v  = 2 * m_c - HALF;
      dt = int'(dead_ticks);
      for (int k = 0; k < 3; k++) begin
         ph = (m_ph + (k * (2 ** PW) + 1) / 3) % (2 ** PW);
         s  = ref_of(ph, m_amp);
         d  = (s > v) ? 1 : 0;
         if (d != m_cur[k]) begin
            m_cur[k] = d; m_cnt[k] = dt;
            m_hi[k] = (dt == 0) ? d : 0;
            m_lo[k] = (dt == 0) ? 1 - d : 0;
         end else if (m_cnt[k] != 0) begin
            m_hi[k] = (m_cnt[k] == 1) ? m_cur[k] : 0;
            m_lo[k] = (m_cnt[k] == 1) ? 1 - m_cur[k] : 0;
            m_cnt[k]--;
         end else begin
            m_hi[k] = m_cur[k]; m_lo[k] = 1 - m_cur[k];
         end
      end
      if (m_c == HALF) begin
         m_amp = (int'(amp_in) >= HALF) ? HALF : int'(amp_in);
         m_ph  = int'(phase_in);
      end
      if (m_up == 1) begin
         if (m_c == HALF - 1) m_up = 0;
         m_c++;
      end else begin
         if (m_c == 1) m_up = 1;
         m_c--;
      end
   endfunction

   // driver: compute expected, queue it, raise tick for one clock
   task automatic step(input string req);
      @(negedge clk);
      model_step();
      exp_q.push_back({3'(m_hi[2]), 3'(m_hi[1]), 3'(m_hi[0])} == 0 ?
                      {3'b000, 3'(m_lo[2] * 4 + m_lo[1] * 2 + m_lo[0])} :
                      {3'(m_hi[2] * 4 + m_hi[1] * 2 + m_hi[0]),
                       3'(m_lo[2] * 4 + m_lo[1] * 2 + m_lo[0])});
      tag_q.push_back(req);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   // monitor: results are due at the edge carrying the tick
   always begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
         logic [5:0] e;
         string      t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, int'({gate_hi, gate_lo}), int'(e));
         check("R8 no overlap", int'(gate_hi & gate_lo), 0);
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R1 reset hi", int'(gate_hi), 0);
      check("R1 reset lo", int'(gate_lo), 0);
      model_reset();
      rst = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   logic [5:0] pat [100];

   initial begin
      int cnt_hi;
      logic [5:0] held;
      model_reset();
      do_reset();

      // R3: zero amplitude, no dead time -> half duty
      repeat (50) step("R3 carrier");
      cnt_hi = 0;
      for (int i = 0; i < 50; i++) begin
         step("R3 carrier");
         cnt_hi += int'(gate_hi[0]);
      end
      check("R3 duty", cnt_hi, HALF);

      // R7: inputs ignored before first peak
      do_reset();
      amp_in = 8'd25; phase_in = 8'd64;
      repeat (13) step("R7 before peak");
      check("R7 pre-peak hi", int'(gate_hi[0]), 1);
      step("R7 before peak");
      check("R7 pre-peak lo", int'(gate_hi[0]), 0);
      repeat (80) step("R4 reference");

      // R9 / R5 / R4 with dead time
      do_reset();
      dead_ticks = 4'd3; amp_in = 8'd20; phase_in = 8'd40;
      repeat (200) step("R9 dead time");

      // R2: no change without tick
      held = {gate_hi, gate_lo};
      repeat (7) @(negedge clk);
      check("R2 hold", int'({gate_hi, gate_lo}), int'(held));

      // R6: saturation equals full scale
      do_reset();
      dead_ticks = 4'd0; phase_in = 8'd20; amp_in = 8'd200;
      for (int i = 0; i < 100; i++) begin
         step("R6 saturate");
         pat[i] = {gate_hi, gate_lo};
      end
      do_reset();
      amp_in = 8'd25;
      cnt_hi = 0;
      for (int i = 0; i < 100; i++) begin
         step("R6 full scale");
         if ({gate_hi, gate_lo} != pat[i]) cnt_hi++;
      end
      check("R6 same as full scale", cnt_hi, 0);

      // R7: inputs wander off-peak
      do_reset();
      dead_ticks = 4'd1;
      for (int i = 0; i < 150; i++) begin
         if (i % 7 == 3) begin
            amp_in   = 8'((i * 5) % 40);
            phase_in = 8'(i * 37);
         end
         step("R7 capture");
      end

      // R5 / R10: sweeping phase, dead time 2, mid-run reset
      do_reset();
      dead_ticks = 4'd2; amp_in = 8'd18;
      for (int i = 0; i < 300; i++) begin
         phase_in = 8'(i * 3);
         step("R5 leg offsets");
      end
      do_reset();
      dead_ticks = 4'd0; amp_in = 8'd9;
      repeat (60) step("R10 latency");

      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule